// File: doc/BRIEF.md
# Burst Address Generator with Selectable Burst Order

This block holds the address register and the two-bit burst counter at the front of a synchronous burst memory. On a clock edge where a load strobe is active, the register captures the incoming address and the counter clears. On later edges, an active-low advance input steps the counter. The address presented to the array is formed every cycle from the captured address and the count.

There are two active-low load strobes. The controller strobe loads on its own. The processor strobe loads only while the active-low chip enable is asserted. A static order input chooses how the count is combined with the two least significant captured bits:
- Low selects linear order: the bits are added with wrap inside the group of four.
- High selects interleaved order: the bits are XORed.

The bits above the burst field are never altered by the counter.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, and after reset until the first load, `addr_out` is all zeros.
- R2: When `ld_ctl_n` is low at a rising edge, `addr_out` equals the `addr_in` of that edge from the next cycle on, whatever `ce_n` is.
- R3: When `ld_cpu_n` and `ce_n` are both low at a rising edge, `addr_out` equals the `addr_in` of that edge from the next cycle on.
- R4: When `ld_cpu_n` is low, `ce_n` is high, `ld_ctl_n` is high and `adv_n` is high at an edge, `addr_out` is unchanged in the next cycle.
- R5: With no load at an edge and `adv_n` low, the burst count (0 to 3) steps by one, wrapping from 3 to 0.
- R6: With no load at an edge and `adv_n` high, `addr_out` keeps its value.
- R7: With `order_ilv` low (linear), `addr_out[1:0]` equals (captured bits [1:0] + count) modulo 4.
- R8: With `order_ilv` high (interleaved), `addr_out[1:0]` equals captured bits [1:0] XOR count.
- R9: A load and an advance at the same edge perform the load only: the count becomes zero.
- R10: `addr_out[ADDR_W-1:2]` changes only on an edge with a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_ctl_n | input | 1 | Controller load strobe, active low, ungated |
| ld_cpu_n | input | 1 | Processor load strobe, active low, gated by `ce_n` |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_ilv | input | 1 | Burst order: 0 linear, 1 interleaved; static |
| addr_in | input | ADDR_W | Address captured on a load |
| addr_out | output | ADDR_W | Effective array address for the current cycle |

## Verification
The assertions assume that `order_ilv` holds its value whenever reset is released, because the order is a static strap. Under that assumption, a change of `addr_out` can only follow a load or an advance. The assertions also assume that the strobes are inactive during reset, since any check reaching back into reset is masked for one cycle after release. The stimulus changes the order input only while reset is held. It keeps every strobe and the advance input high during reset, and it drives all inputs on the falling edge.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

  localparam int unsigned BURST_BITS = 2;

  typedef logic [BURST_BITS-1:0] burst_t;

  typedef enum logic {
    ORDER_LINEAR      = 1'b0,
    ORDER_INTERLEAVED = 1'b1
  } burst_order_e;

  // Linear order: add and wrap inside the burst group.
  function automatic burst_t offs_linear(input burst_t start, input burst_t step);
    return burst_t'(start + step);
  endfunction

  // Interleaved order: flip the start bits by the count.
  function automatic burst_t offs_interleave(input burst_t start, input burst_t step);
    return start ^ step;
  endfunction

  function automatic burst_t offs_select(input burst_order_e ord, input burst_t start,
                                         input burst_t step);
    return (ord == ORDER_INTERLEAVED) ? offs_interleave(start, step)
                                      : offs_linear(start, step);
  endfunction

endpackage

// File: rtl/bag_strobe_dec.sv
module bag_strobe_dec (
  input  logic ld_ctl_n,
  input  logic ld_cpu_n,
  input  logic ce_n,
  input  logic adv_n,
  output logic load_evt,
  output logic step_evt
);
  logic cpu_gated;

  always_comb begin
    cpu_gated = ~ld_cpu_n & ~ce_n;
    load_evt  = ~ld_ctl_n | cpu_gated;
    step_evt  = ~adv_n & ~load_evt;
  end
endmodule

// File: rtl/bag_burst_ctr.sv
module bag_burst_ctr
  import burst_addr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load_evt,
  input  logic   step_evt,
  output burst_t count
);
  always_ff @(posedge clk) begin
    if (!rst_n)        count <= '0;
    else if (load_evt) count <= '0;
    else if (step_evt) count <= burst_t'(count + burst_t'(1));
  end
endmodule

// File: rtl/bag_addr_reg.sv
module bag_addr_reg #(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_evt,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] base_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)        base_q <= '0;
    else if (load_evt) base_q <= addr_in;
  end
endmodule

// File: rtl/bag_order_map.sv
module bag_order_map
  import burst_addr_pkg::*;
#(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              order_ilv,
  input  logic [ADDR_W-1:0] base_q,
  input  burst_t            count,
  output logic [ADDR_W-1:0] addr_eff
);
  localparam int unsigned HI_W = ADDR_W - BURST_BITS;

  burst_order_e ord;
  burst_t       low_eff;

  always_comb begin
    ord      = burst_order_e'(order_ilv);
    low_eff  = offs_select(ord, base_q[BURST_BITS-1:0], count);
    addr_eff = {base_q[ADDR_W-1 -: HI_W], low_eff};
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_ctl_n,
  input  logic              ld_cpu_n,
  input  logic              ce_n,
  input  logic              adv_n,
  input  logic              order_ilv,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);
  logic              load_evt;
  logic              step_evt;
  burst_t            burst_cnt;
  logic [ADDR_W-1:0] base_q;

  bag_strobe_dec u_dec (
    .ld_ctl_n (ld_ctl_n),
    .ld_cpu_n (ld_cpu_n),
    .ce_n     (ce_n),
    .adv_n    (adv_n),
    .load_evt (load_evt),
    .step_evt (step_evt)
  );

  bag_addr_reg #(.ADDR_W(ADDR_W)) u_areg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_evt (load_evt),
    .addr_in  (addr_in),
    .base_q   (base_q)
  );

  bag_burst_ctr u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_evt (load_evt),
    .step_evt (step_evt),
    .count    (burst_cnt)
  );

  bag_order_map #(.ADDR_W(ADDR_W)) u_map (
    .order_ilv (order_ilv),
    .base_q    (base_q),
    .count     (burst_cnt),
    .addr_eff  (addr_out)
  );
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk
  import burst_addr_pkg::*;
#(
  parameter int unsigned ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_ctl_n,
  input logic              ld_cpu_n,
  input logic              ce_n,
  input logic              adv_n,
  input logic              order_ilv,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out,
  input logic              load_evt,
  input logic              step_evt,
  input burst_t            burst_cnt
);
  logic live_q;

  always_ff @(posedge clk) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  always_comb begin
    if (!rst_n) assert_reset_zero_R1: assert (burst_cnt == '0 || $isunknown(burst_cnt));
  end

  assert_ctl_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !ld_ctl_n) |=> addr_out == $past(addr_in));

  assert_cpu_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !ld_cpu_n && !ce_n) |=> addr_out == $past(addr_in));

  assert_cpu_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !ld_cpu_n && ce_n && ld_ctl_n && adv_n) |=> $stable(addr_out));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !load_evt && adv_n) |=> $stable(addr_out));

  assert_linear_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && step_evt && !order_ilv) |=>
      addr_out[BURST_BITS-1:0] == burst_t'($past(addr_out[BURST_BITS-1:0]) + burst_t'(1)));

  assert_load_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && load_evt && !adv_n) |=> burst_cnt == '0);

  assert_upper_fixed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !load_evt) |=> $stable(addr_out[ADDR_W-1:BURST_BITS]));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ld_ctl_n  (ld_ctl_n),
  .ld_cpu_n  (ld_cpu_n),
  .ce_n      (ce_n),
  .adv_n     (adv_n),
  .order_ilv (order_ilv),
  .addr_in   (addr_in),
  .addr_out  (addr_out),
  .load_evt  (load_evt),
  .step_evt  (step_evt),
  .burst_cnt (burst_cnt)
);

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_ctl_n = 1'b1, ld_cpu_n = 1'b1, ce_n = 1'b1, adv_n = 1'b1, order_ilv = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {
    logic [AW-1:0] exp;
    string         tag;
  } item_t;
  item_t sb_q[$];

  logic [AW-1:0] m_base = '0;
  int            m_cnt  = 0;
  bit            done   = 1'b0;

  burst_addr_gen #(.ADDR_W(AW)) u_burst_addr_gen (
    .clk(clk), .rst_n(rst_n), .ld_ctl_n(ld_ctl_n), .ld_cpu_n(ld_cpu_n),
    .ce_n(ce_n), .adv_n(adv_n), .order_ilv(order_ilv), .addr_in(addr_in),
    .addr_out(addr_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [AW-1:0] model_addr(input logic [AW-1:0] b, input int c, input logic ilv);
    int lo;
    int s;
    s  = int'(b[1:0]);
    lo = ilv ? (s ^ c) : ((s + c) % 4);
    return {b[AW-1:2], 2'(lo)};
  endfunction

  task automatic check(input logic [AW-1:0] got, input logic [AW-1:0] exp, input string tag);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: addr_out=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic c_n, input logic p_n, input logic e_n, input logic a_n,
                       input logic [AW-1:0] a, input string tag);
    item_t it;
    @(negedge clk);
    ld_ctl_n = c_n; ld_cpu_n = p_n; ce_n = e_n; adv_n = a_n; addr_in = a;
    if (!c_n || (!p_n && !e_n)) begin
      m_base = a;
      m_cnt  = 0;
    end else if (!a_n) begin
      m_cnt = (m_cnt + 1) % 4;
    end
    it.exp = model_addr(m_base, m_cnt, order_ilv);
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(addr_out, it.exp, it.tag);
    end
  end

  task automatic do_reset(input logic ilv);
    @(negedge clk);
    rst_n = 1'b0; ld_ctl_n = 1'b1; ld_cpu_n = 1'b1; ce_n = 1'b1; adv_n = 1'b1;
    order_ilv = ilv;
    m_base = '0; m_cnt = 0;
    repeat (3) @(negedge clk);
    check(addr_out, '0, "R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(addr_out, '0, "R1 after reset");
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset(1'b0);
    // Linear phase
    drive(0, 1, 1, 1, 18'h12345, "R2 ctl load with ce_n high");
    drive(1, 1, 1, 0, 18'h3ffff, "R5 R7 R10 linear step 1");
    drive(1, 1, 1, 0, 18'h3ffff, "R5 R7 linear step 2");
    drive(1, 1, 1, 1, 18'h3ffff, "R6 hold");
    drive(1, 1, 1, 0, 18'h00000, "R5 R7 linear wrap to 0");
    drive(1, 1, 1, 0, 18'h00000, "R5 R7 R10 linear back to start");
    drive(1, 0, 1, 1, 18'h2abcd, "R4 cpu strobe without ce ignored");
    drive(1, 1, 1, 1, 18'h2abcd, "R4 still unchanged");
    drive(1, 0, 0, 1, 18'h0beef, "R3 cpu load with ce");
    drive(1, 1, 0, 0, 18'h11111, "R5 R7 step after cpu load");
    drive(0, 1, 1, 0, 18'h2aaa6, "R9 load beats advance");
    drive(1, 1, 1, 0, 18'h00000, "R7 R9 first step after load");
    drive(1, 0, 0, 0, 18'h15551, "R9 R3 cpu load beats advance");
    drive(1, 1, 1, 1, 18'h15551, "R6 hold after load");
    repeat (3) @(negedge clk);
    // Interleaved phase
    do_reset(1'b1);
    drive(0, 1, 0, 1, 18'h2fffe, "R2 load interleaved");
    drive(1, 1, 1, 0, 18'h00000, "R8 interleave step 1");
    drive(1, 1, 1, 0, 18'h00000, "R8 interleave step 2");
    drive(1, 1, 1, 0, 18'h00000, "R8 R10 interleave step 3");
    drive(1, 1, 1, 0, 18'h00000, "R8 R5 interleave wrap");
    drive(0, 1, 1, 1, 18'h0c0d1, "R2 reload interleaved");
    drive(1, 1, 1, 0, 18'h00000, "R8 step from 01");
    drive(1, 1, 1, 1, 18'h00000, "R6 hold interleaved");
    drive(1, 1, 1, 0, 18'h00000, "R8 step from 01 count 2");
    drive(1, 1, 1, 1, 18'h00000, "R6 idle");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule